// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the two modem registers of a serial port: a control register that drives the four handshake outputs, selects an internal loopback path and enables automatic flow control, and a status register that reports the four incoming handshake lines together with a latched change flag for each. Software writes the control register and reads the status register over a small register bus. Incoming lines are resynchronised to the core clock before any edge is detected. The unit raises an interrupt request whenever a change flag is pending and the modem-status interrupt is enabled.

In loopback the handshake outputs are routed back internally as inputs: clear-to-send follows request-to-send, data-set-ready follows data-terminal-ready, ring follows the first user output, and carrier-detect follows the second user output. The external inputs are then ignored and the outside-facing outputs are held inactive. This lets driver code exercise the whole status path with no cable attached.

Top module: `mdm_ctl_stat`

## Requirements
- R1: A write to address 0 loads the control register: bit 0 terminal-ready, bit 1 request-to-send, bit 2 user output 1, bit 3 user output 2, bit 4 loopback, bit 5 auto flow enable. A read of address 0 returns these six bits with bits 7:6 as zero.
- R2: With loopback off, the outputs dtr_o, rts_o, out1_o and out2_o follow control bits 0 to 3. afe_o always follows bit 5.
- R3: With loopback on, dtr_o, rts_o, out1_o and out2_o are 0. The status levels take CTS from bit 1, DSR from bit 0, RI from bit 2 and DCD from bit 3, and the external inputs have no effect.
- R4: A read of address 1 returns the status byte, with current levels in the upper nibble: CTS bit 4, DSR bit 5, RI bit 6, DCD bit 7. An external line change is visible there within four clock cycles.
- R5: A change in either direction on CTS, DSR or DCD sets its flag: CTS bit 0, DSR bit 1, DCD bit 3.
- R6: The ring flag (bit 2) is set only when RI goes from 1 to 0. A 0-to-1 change of RI sets no flag.
- R7: A read of address 1 clears all four flags. A read that directly follows it returns only the levels.
- R8: irq_o is 1 exactly while msi_en_i is 1 and at least one flag is set. It drops after the clearing read.
- R9: Several lines changing in the same cycle set all of their flags together.
- R10: When a line change falls in the same cycle as a clearing status read, the read returns the old byte and the new flag stays set.
- R11: After reset the control register, the status byte, irq_o and all outputs are 0.
- R12: Writes to address 1 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (status read clears the flags) |
| bus_addr_i | input | AW | Register address: 0 control, 1 status |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for the addressed register, combinational |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| cts_i | input | 1 | External clear-to-send, active high |
| dsr_i | input | 1 | External data-set-ready, active high |
| ri_i | input | 1 | External ring indicator, active high |
| dcd_i | input | 1 | External carrier detect, active high |
| dtr_o | output | 1 | Terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | User output 1 |
| out2_o | output | 1 | User output 2 |
| afe_o | output | 1 | Auto flow enable, for the transmitter's gating logic |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The clearing status read and a fresh line change can land in the same clock edge. If the clear is applied after the new event, the event is lost without notice. The bench times an external CTS change through the two synchroniser stages so that the flag-setting edge is the same edge that performs the status read. It then checks that this read returns the old byte and that the next read shows the new delta flag. A second pair that must be judged together is loopback entry and exit: there the source of the levels switches, and the bench checks the flags this sets from the known old and new levels.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  localparam int unsigned CTL_W  = 6;
  localparam int unsigned LINE_W = 4;

  // Control register layout, bit 0 at the bottom
  typedef struct packed {
    logic afe;
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctl_t;

  // Handshake line order: the same for the levels nibble and the flags nibble
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;

  // Internal wrap of outputs onto inputs when loopback is selected
  function automatic line_t loop_lines(input ctl_t c);
    line_t l;
    l.cts = c.rts;
    l.dsr = c.dtr;
    l.ri  = c.out1;
    l.dcd = c.out2;
    return l;
  endfunction

  // Change events between two successive level samples
  function automatic line_t change_events(input line_t prev, input line_t cur);
    line_t e;
    e.cts = prev.cts ^ cur.cts;
    e.dsr = prev.dsr ^ cur.dsr;
    e.dcd = prev.dcd ^ cur.dcd;
    e.ri  = prev.ri & ~cur.ri;
    return e;
  endfunction

  function automatic logic [2*LINE_W-1:0] pack_status(input line_t lvl, input line_t flg);
    return {lvl, flg};
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output ctl_t          ctl_o,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          out1_o,
  output logic          out2_o,
  output logic          afe_o
);

  ctl_t ctl_q;
  logic unused_hi;

  assign unused_hi = ^wdata_i[DW-1:CTL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (wr_i) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
  end

  // Pins go quiet while the outputs are wrapped back internally
  logic pin_en;
  assign pin_en = ~ctl_q.loop;

  assign dtr_o  = ctl_q.dtr  & pin_en;
  assign rts_o  = ctl_q.rts  & pin_en;
  assign out1_o = ctl_q.out1 & pin_en;
  assign out2_o = ctl_q.out2 & pin_en;
  assign afe_o  = ctl_q.afe;
  assign ctl_o  = ctl_q;

endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_t lines_i,
  input  logic  clr_i,
  output line_t lvl_o,
  output line_t flag_o,
  output line_t evt_o,
  output logic  ri_rise_o
);

  line_t lvl_q;
  line_t flag_q;
  line_t evt_w;

  assign evt_w     = change_events(lvl_q, lines_i);
  assign ri_rise_o = ~lvl_q.ri & lines_i.ri;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lines_i;
  end

  // A new event in the clearing cycle survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= '0;
    else if (clr_i) flag_q <= evt_w;
    else            flag_q <= flag_q | evt_w;
  end

  assign lvl_o  = lvl_q;
  assign flag_o = flag_q;
  assign evt_o  = evt_w;

endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
  import mdm_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [AW-1:0] CTRL_ADDR = 0,
  parameter logic [AW-1:0] STAT_ADDR = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          msi_en_i,
  input  logic          cts_i,
  input  logic          dsr_i,
  input  logic          ri_i,
  input  logic          dcd_i,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          out1_o,
  output logic          out2_o,
  output logic          afe_o,
  output logic          irq_o
);

  localparam int unsigned STAT_W = 2 * LINE_W;

  // Named events for the checker
  logic  ctl_wr_w;
  logic  stat_wr_w;
  logic  stat_rd_w;
  ctl_t  ctl_q;
  line_t ext_raw;
  line_t ext_sync;
  line_t eff_lines;
  line_t lvl_q;
  line_t flag_q;
  line_t evt_w;
  logic  ri_rise_w;

  assign ctl_wr_w  = bus_wr_i & (bus_addr_i == CTRL_ADDR);
  assign stat_wr_w = bus_wr_i & (bus_addr_i == STAT_ADDR);
  assign stat_rd_w = bus_rd_i & (bus_addr_i == STAT_ADDR);

  mdm_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_w),
    .wdata_i (bus_wdata_i),
    .ctl_o   (ctl_q),
    .dtr_o   (dtr_o),
    .rts_o   (rts_o),
    .out1_o  (out1_o),
    .out2_o  (out2_o),
    .afe_o   (afe_o)
  );

  assign ext_raw.cts = cts_i;
  assign ext_raw.dsr = dsr_i;
  assign ext_raw.ri  = ri_i;
  assign ext_raw.dcd = dcd_i;

  mdm_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_raw),
    .sync_o  (ext_sync)
  );

  assign eff_lines = ctl_q.loop ? loop_lines(ctl_q) : ext_sync;

  mdm_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lines_i   (eff_lines),
    .clr_i     (stat_rd_w),
    .lvl_o     (lvl_q),
    .flag_o    (flag_q),
    .evt_o     (evt_w),
    .ri_rise_o (ri_rise_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == CTRL_ADDR)      bus_rdata_o[CTL_W-1:0]  = ctl_q;
    else if (bus_addr_i == STAT_ADDR) bus_rdata_o[STAT_W-1:0] = pack_status(lvl_q, flag_q);
  end

  assign irq_o = msi_en_i & (|flag_q);

endmodule

// File: rtl/mdm_chk.sv
module mdm_chk
  import mdm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctl_wr_w,
  input logic          stat_wr_w,
  input logic          stat_rd_w,
  input logic [DW-1:0] bus_wdata_i,
  input ctl_t          ctl_q,
  input line_t         flag_q,
  input line_t         evt_w,
  input logic          ri_rise_w,
  input logic          dtr_o,
  input logic          rts_o,
  input logic          out1_o,
  input logic          out2_o,
  input logic          irq_o
);

  // R1
  ctl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_w |=> ctl_q == $past(bus_wdata_i[CTL_W-1:0]));

  // R3
  loop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.loop |-> !(dtr_o || rts_o || out1_o || out2_o));

  // R5
  cts_delta_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_w.cts |=> flag_q.cts);

  // R6
  ri_rise_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_rise_w && !flag_q.ri) |=> !flag_q.ri);

  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_w && evt_w == '0) |=> flag_q == '0);

  // R8
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_w && evt_w == '0) |=> !irq_o);

  // R10
  race_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_w && evt_w.dcd) |=> flag_q.dcd);

  // R12
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_w && !stat_rd_w && evt_w == '0) |=> $stable(flag_q));

endmodule

bind mdm_ctl_stat mdm_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_wr_w    (ctl_wr_w),
  .stat_wr_w   (stat_wr_w),
  .stat_rd_w   (stat_rd_w),
  .bus_wdata_i (bus_wdata_i),
  .ctl_q       (ctl_q),
  .flag_q      (flag_q),
  .evt_w       (evt_w),
  .ri_rise_w   (ri_rise_w),
  .dtr_o       (dtr_o),
  .rts_o       (rts_o),
  .out1_o      (out1_o),
  .out2_o      (out2_o),
  .irq_o       (irq_o)
);

// File: tb/tb_mdm_ctl_stat.sv
`timescale 1ns/1ps
module tb_mdm_ctl_stat;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [0:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       msi_en = 1'b0;
  logic       cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
  logic       dtr, rts, out1, out2, afe, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mdm_ctl_stat dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .msi_en_i(msi_en), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2),
    .afe_o(afe), .irq_o(irq)
  );

  // op[17:16]: 0 write control, 1 read control, 2 read status, 3 write status
  localparam int NV = 30;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h10, 8'h00}, {2'd1, 8'h00, 8'h10}, {2'd2, 8'h00, 8'h00}, // R1 R3
    {2'd0, 8'h11, 8'h00}, {2'd2, 8'h00, 8'h22}, {2'd2, 8'h00, 8'h20}, // R5 R7
    {2'd0, 8'h13, 8'h00}, {2'd2, 8'h00, 8'h31}, {2'd2, 8'h00, 8'h30},
    {2'd0, 8'h17, 8'h00}, {2'd2, 8'h00, 8'h70},                       // R6 rise
    {2'd0, 8'h13, 8'h00}, {2'd2, 8'h00, 8'h34}, {2'd2, 8'h00, 8'h30}, // R6 fall
    {2'd0, 8'h1B, 8'h00}, {2'd2, 8'h00, 8'hB8}, {2'd2, 8'h00, 8'hB0},
    {2'd0, 8'h10, 8'h00}, {2'd2, 8'h00, 8'h0B}, {2'd2, 8'h00, 8'h00}, // R9
    {2'd3, 8'hFF, 8'h00}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'h00, 8'h10}, // R12
    {2'd0, 8'hFF, 8'h00}, {2'd1, 8'h00, 8'h3F}, {2'd2, 8'h00, 8'hFB}, // R1 R9
    {2'd2, 8'h00, 8'hF0},
    {2'd0, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h0F}, {2'd2, 8'h00, 8'h00}  // R9 exit
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    check("R11 pins", {3'b0, afe, out2, out1, rts, dtr}, 8'h00);
    check("R11 irq", {7'b0, irq}, 8'h00);
    rd_chk("R11 control", 1'b0, 8'h00);
    rd_chk("R11 status", 1'b1, 8'h00);

    // Vector table, loopback sequence with external lines idle
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: bus_write(1'b0, VEC[i][15:8]);
        2'd3: bus_write(1'b1, VEC[i][15:8]);
        2'd1: rd_chk($sformatf("R1 table[%0d]", i), 1'b0, VEC[i][7:0]);
        default: rd_chk($sformatf("R3/R5/R6/R7/R9 table[%0d]", i), 1'b1, VEC[i][7:0]);
      endcase
    end

    // R4 R5 external CTS through the synchroniser
    @(negedge clk); cts = 1'b1;
    settle();
    rd_chk("R4 R5 cts rise", 1'b1, 8'h11);
    rd_chk("R7 cts level only", 1'b1, 8'h10);

    // R8 interrupt request
    msi_en = 1'b1;
    @(negedge clk); dsr = 1'b1;
    settle();
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    rd_chk("R8 status", 1'b1, 8'h32);
    check("R8 irq dropped", {7'b0, irq}, 8'h00);
    msi_en = 1'b0;
    @(negedge clk); dsr = 1'b0;
    settle();
    check("R8 irq masked", {7'b0, irq}, 8'h00);
    rd_chk("R8 masked flag", 1'b1, 8'h12);

    // R6 external ring
    @(negedge clk); ri = 1'b1;
    settle();
    rd_chk("R6 ri rise no flag", 1'b1, 8'h50);
    @(negedge clk); ri = 1'b0;
    settle();
    rd_chk("R6 ri trailing edge", 1'b1, 8'h14);

    // R3 external lines ignored in loopback
    bus_write(1'b0, 8'h10);
    rd_chk("R3 enter loop", 1'b1, 8'h01);
    @(negedge clk); dcd = 1'b1;
    settle();
    rd_chk("R3 ext ignored", 1'b1, 8'h00);
    bus_write(1'b0, 8'h1F);
    check("R3 pins quiet", {4'b0, out2, out1, rts, dtr}, 8'h00);
    bus_write(1'b0, 8'h00);
    bus_read(1'b1, v);

    // R2 pin outputs
    bus_write(1'b0, 8'h2F);
    check("R2 pins follow", {3'b0, afe, out2, out1, rts, dtr}, 8'h1F);
    bus_write(1'b0, 8'h3F);
    check("R2 R3 afe kept, pins off", {3'b0, afe, out2, out1, rts, dtr}, 8'h10);
    bus_write(1'b0, 8'h00);
    settle();
    bus_read(1'b1, v);
    rd_chk("R4 levels after loop exit", 1'b1, 8'h90);

    // R10 clearing read in the same edge as a CTS change
    @(negedge clk); cts = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd = 1'b1; addr = 1'b1;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    check("R10 old byte", v, 8'h90);
    rd_chk("R10 new flag kept", 1'b1, 8'h81);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule